// File: doc/BRIEF.md
# Single-Input Three-Port Packet Router

This block receives byte-wide packets on one input and forwards each one to one of three output queues. The first byte of a packet is a header. Its low two bits name the destination, and its upper six bits give the payload length. The payload bytes follow the header, and a final check byte closes the packet. A controller compares the destination against the 8-bit address assigned to each output port. It copies every byte of a matching packet (header, payload and check byte) into that port's FIFO. It also keeps a running XOR so that it can verify the check byte.

The sender presents a byte with `in_valid` and must hold it while `suspend` is high. This happens whenever the byte would be written into an output FIFO that is full. Each output port drains through its own first-word-fall-through read interface. A packet addressed to no port is consumed in full and thrown away. A header with a zero length is consumed on its own and dropped.

Top module: `pkt_router3`

## Requirements
- R1: Header bits [1:0] hold the destination and bits [7:2] hold the payload length. The destination, zero-extended to 8 bits, is compared with each port's 8-bit address. On a match, the header, every payload byte and the check byte are queued, in arrival order, on the matching port only.
- R2: A header whose length field is 0 is consumed alone. It writes no FIFO, raises no error, and the next accepted byte is treated as a new header.
- R3: A packet whose destination equals no port address is consumed in full (length + 2 bytes) and writes no FIFO.
- R4: The check byte must equal the XOR of the header and all payload bytes. When it differs, `error` is high for exactly one cycle, the cycle after the check byte is accepted. This applies to discarded packets as well.
- R5: `suspend` is high while `in_valid` presents a byte bound for a full FIFO. While it is high, the byte is not consumed, and a full FIFO is never written.
- R6: Each output port shows `out_valid` while its FIFO holds data, with the oldest byte on its `out_data` lane. A byte is removed only on a cycle with both `out_rd` and `out_valid` high. Otherwise the lane is held unchanged.
- R7: After reset, all `out_valid` bits, `suspend` and `error` are low, and every FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| suspend | output | 1 | Sender must hold the current byte |
| error | output | 1 | One-cycle pulse on a check-byte mismatch |
| out_valid | output | 3 | Per-port FIFO not empty |
| out_rd | input | 3 | Per-port read strobe |
| out_data | output | 24 | Per-port head byte, port i on bits [8i+7:8i] |

## Verification
The bench builds the router with a FIFO depth of 4 instead of 16, so that ordinary packets of a few bytes fill a queue and `suspend` appears often under random read pressure. It sets the port addresses to 1, 3 and 0 for ports 0, 1 and 2. This makes the mapping from destination to port non-trivial and leaves destination 2 unmatched, so that the discard path is reached with legal header values.

// File: rtl/router_pkg.sv
package router_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_CHECK = 2'd2
    } rt_state_e;

endpackage

// File: rtl/router_addr_match.sv
module router_addr_match #(
    parameter int W      = 8,
    parameter int DEST_W = 2,
    parameter int NPORT  = 3,
    parameter logic [NPORT*W-1:0] PORT_ADDR = '0,
    parameter int IDX_W  = $clog2(NPORT)
) (
    input  logic [DEST_W-1:0] dest,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    logic [NPORT-1:0] match;
    logic [W-1:0]     dest_ext;

    assign dest_ext = {{(W-DEST_W){1'b0}}, dest};

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_cmp
        assign match[gi] = (dest_ext == PORT_ADDR[gi*W +: W]);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/router_fifo.sv
module router_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         not_empty,
    output logic         full
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_s;

    fifo_s        fs_q, fs_d;
    logic [W-1:0] mem [DEPTH];
    logic         do_wr, do_rd;

    assign full      = (fs_q.cnt == (AW+1)'(DEPTH));
    assign not_empty = (fs_q.cnt != '0);
    assign do_wr     = wr_en && !full;
    assign do_rd     = rd_en && not_empty;
    assign rd_data   = mem[fs_q.rp];

    always_comb begin
        fs_d = fs_q;
        if (do_wr) begin
            fs_d.wp = (fs_q.wp == AW'(DEPTH-1)) ? '0 : fs_q.wp + 1'b1;
        end
        if (do_rd) begin
            fs_d.rp = (fs_q.rp == AW'(DEPTH-1)) ? '0 : fs_q.rp + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   fs_d.cnt = fs_q.cnt + 1'b1;
            2'b01:   fs_d.cnt = fs_q.cnt - 1'b1;
            default: fs_d.cnt = fs_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[fs_q.wp] <= wr_data;
    end

endmodule

// File: rtl/router_ctrl.sv
module router_ctrl
    import router_pkg::*;
#(
    parameter int W      = 8,
    parameter int DEST_W = 2,
    parameter int NPORT  = 3,
    parameter int IDX_W  = $clog2(NPORT),
    parameter int LEN_W  = W - DEST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_data,
    input  logic             m_hit,
    input  logic [IDX_W-1:0] m_idx,
    input  logic [NPORT-1:0] fifo_full,
    output logic [NPORT-1:0] wr_en,
    output logic             suspend,
    output logic             error,
    output logic             hdr_phase
);

    typedef struct packed {
        rt_state_e       st;
        logic            hit;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] left;
        logic [W-1:0]    par;
        logic            err;
    } ctrl_s;

    ctrl_s            cs_q, cs_d;
    logic [LEN_W-1:0] hdr_len;
    logic             cur_hit;
    logic [IDX_W-1:0] cur_idx;
    logic             take;

    assign hdr_len   = in_data[W-1:DEST_W];
    assign hdr_phase = (cs_q.st == ST_IDLE);
    assign error     = cs_q.err;

    always_comb begin
        cs_d     = cs_q;
        cs_d.err = 1'b0;
        wr_en    = '0;
        cur_hit  = hdr_phase ? (m_hit && hdr_len != '0) : cs_q.hit;
        cur_idx  = hdr_phase ? m_idx : cs_q.idx;
        suspend  = in_valid && cur_hit && fifo_full[cur_idx];
        take     = in_valid && !suspend;
        if (take) begin
            if (cur_hit) wr_en[cur_idx] = 1'b1;
            case (cs_q.st)
                ST_IDLE: begin
                    if (hdr_len != '0) begin
                        cs_d.st   = ST_BODY;
                        cs_d.hit  = m_hit;
                        cs_d.idx  = m_idx;
                        cs_d.left = hdr_len;
                        cs_d.par  = in_data;
                    end
                end
                ST_BODY: begin
                    cs_d.par  = cs_q.par ^ in_data;
                    cs_d.left = cs_q.left - 1'b1;
                    if (cs_q.left == LEN_W'(1)) cs_d.st = ST_CHECK;
                end
                ST_CHECK: begin
                    cs_d.err = (in_data != cs_q.par);
                    cs_d.st  = ST_IDLE;
                    cs_d.hit = 1'b0;
                end
                default: cs_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

endmodule

// File: rtl/pkt_router3.sv
module pkt_router3 #(
    parameter int W      = 8,
    parameter int DEST_W = 2,
    parameter int NPORT  = 3,
    parameter int DEPTH  = 16,
    parameter logic [NPORT*W-1:0] PORT_ADDR = {8'd2, 8'd1, 8'd0}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [W-1:0]       in_data,
    output logic               suspend,
    output logic               error,
    output logic [NPORT-1:0]   out_valid,
    input  logic [NPORT-1:0]   out_rd,
    output logic [NPORT*W-1:0] out_data
);

    localparam int IDX_W = $clog2(NPORT);

    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic [NPORT-1:0] fifo_full;
    logic [NPORT-1:0] wr_en;
    logic             hdr_phase;

    router_addr_match #(
        .W(W), .DEST_W(DEST_W), .NPORT(NPORT), .PORT_ADDR(PORT_ADDR), .IDX_W(IDX_W)
    ) u_match (
        .dest (in_data[DEST_W-1:0]),
        .hit  (m_hit),
        .idx  (m_idx)
    );

    router_ctrl #(
        .W(W), .DEST_W(DEST_W), .NPORT(NPORT), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .m_hit     (m_hit),
        .m_idx     (m_idx),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .suspend   (suspend),
        .error     (error),
        .hdr_phase (hdr_phase)
    );

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        router_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en[gp]),
            .wr_data   (in_data),
            .rd_en     (out_rd[gp]),
            .rd_data   (out_data[gp*W +: W]),
            .not_empty (out_valid[gp]),
            .full      (fifo_full[gp])
        );
    end

endmodule

// File: rtl/router_chk.sv
module router_chk #(
    parameter int W      = 8,
    parameter int DEST_W = 2,
    parameter int NPORT  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [W-1:0]       in_data,
    input logic               suspend,
    input logic               error,
    input logic               hdr_phase,
    input logic [NPORT-1:0]   wr_en,
    input logic [NPORT-1:0]   fifo_full,
    input logic [NPORT-1:0]   out_valid,
    input logic [NPORT-1:0]   out_rd,
    input logic [NPORT*W-1:0] out_data
);

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error); // R4

    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en & fifo_full) == '0); // R5

    AST_SUSP_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> (in_valid && (|fifo_full))); // R5

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)); // R1

    AST_LEN0_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hdr_phase && in_data[W-1:DEST_W] == '0) |-> (wr_en == '0)); // R2

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_hold
        AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[gp] && !out_rd[gp]) |=>
            (out_valid[gp] && $stable(out_data[gp*W +: W]))); // R6
    end

endmodule

bind pkt_router3 router_chk #(.W(W), .DEST_W(DEST_W), .NPORT(NPORT)) u_router_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .suspend   (suspend),
    .error     (error),
    .hdr_phase (hdr_phase),
    .wr_en     (wr_en),
    .fifo_full (fifo_full),
    .out_valid (out_valid),
    .out_rd    (out_rd),
    .out_data  (out_data)
);

// File: tb/pkt_router3_tb_top.sv
`timescale 1ns/1ps
module pkt_router3_tb_top;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        suspend;
    logic        error;
    logic [2:0]  out_valid;
    logic [2:0]  out_rd = '0;
    logic [23:0] out_data;

    int   n_run = 0;
    int   n_fail = 0;
    bit   rd_allow = 1'b0;
    int   rd_pct = 70;
    logic [7:0] exp_q [3][$];

    always #10 clk = ~clk;

    pkt_router3 #(
        .DEPTH(DEPTH),
        .PORT_ADDR({8'd0, 8'd3, 8'd1})
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .suspend(suspend), .error(error), .out_valid(out_valid),
        .out_rd(out_rd), .out_data(out_data)
    );

    function automatic int port_of(input int d);
        case (d)
            1: return 0;
            3: return 1;
            0: return 2;
            default: return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Reader: compares each popped head byte against the model (R1, R3, R6)
    always @(negedge clk) begin
        for (int p = 0; p < 3; p++) begin
            if (rst_n && rd_allow && out_valid[p] && ($urandom % 100) < rd_pct) begin
                if (exp_q[p].size() == 0) begin
                    check(1'b0, "R3 unexpected byte", out_data[p*8 +: 8], 0);
                end else begin
                    check(out_data[p*8 +: 8] == exp_q[p][0], "R1 byte order",
                          out_data[p*8 +: 8], exp_q[p][0]);
                    void'(exp_q[p].pop_front());
                end
                out_rd[p] = 1'b1;
            end else begin
                out_rd[p] = 1'b0;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input int p);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        #5;
        while (suspend) begin
            @(negedge clk);
            #5;
        end
        if (p >= 0) exp_q[p].push_back(b);
    endtask

    task automatic send_pkt(input int dest, input int len, input bit bad);
        logic [7:0] hdr, par, b;
        int p;
        hdr = {len[5:0], dest[1:0]};
        p   = (len == 0) ? -1 : port_of(dest);
        par = hdr;
        send_byte(hdr, p);
        if (len == 0) begin
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            check(error == 1'b0, "R2 no error on empty header", error, 0);
            return;
        end
        for (int i = 0; i < len; i++) begin
            b = 8'($urandom);
            par ^= b;
            send_byte(b, p);
        end
        send_byte(bad ? ~par : par, p);
        @(posedge clk);
        #1;
        check(error == bad, "R4 error pulse", error, bad);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check(error == 1'b0, "R4 error lasts one cycle", error, 0);
    endtask

    task automatic drain();
        rd_allow = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk);
            if (out_valid == '0 && exp_q[0].size() == 0 &&
                exp_q[1].size() == 0 && exp_q[2].size() == 0) break;
        end
        @(negedge clk);
        check(out_valid == '0, "R3 queues empty after drain", out_valid, 0);
        check(exp_q[0].size() + exp_q[1].size() + exp_q[2].size() == 0,
              "R1 all expected bytes delivered",
              exp_q[0].size() + exp_q[1].size() + exp_q[2].size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R7 reset state
        check(out_valid == '0, "R7 out_valid after reset", out_valid, 0);
        check(suspend == 1'b0, "R7 suspend after reset", suspend, 0);
        check(error == 1'b0, "R7 error after reset", error, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_allow = 1'b1;

        // Directed: one packet to each port, good check bytes (R1)
        send_pkt(1, 2, 1'b0);
        send_pkt(3, 1, 1'b0);
        send_pkt(0, 3, 1'b0);
        // R2: zero-length header then a normal packet
        send_pkt(1, 0, 1'b0);
        send_pkt(1, 1, 1'b0);
        // R3 and R4: unmatched destination, bad and good check byte
        send_pkt(2, 4, 1'b1);
        send_pkt(2, 1, 1'b0);
        // R4: bad check on a forwarded packet
        send_pkt(3, 2, 1'b1);
        drain();

        // R5 / R6: fill port 0 (depth 4) with a 7-byte packet while reads are off
        rd_allow = 1'b0;
        @(negedge clk);
        fork
            send_pkt(1, 5, 1'b0);
        join_none
        repeat (15) @(posedge clk);
        #2;
        check(suspend == 1'b1, "R5 suspend while target full", suspend, 1);
        check(in_valid == 1'b1, "R5 byte still held", in_valid, 1);
        check(out_valid[0] == 1'b1, "R6 valid while holding data", out_valid[0], 1);
        held = out_data[7:0];
        check(held == exp_q[0][0], "R6 head is oldest byte", held, exp_q[0][0]);
        repeat (3) @(posedge clk);
        #2;
        check(out_data[7:0] == held, "R6 head stable without read", out_data[7:0], held);
        rd_allow = 1'b1;
        wait fork;
        drain();

        // Random traffic with random read pressure
        for (int k = 0; k < 60; k++) begin
            int d, l;
            d = int'($urandom % 4);
            l = (($urandom % 10) == 0) ? 0 : int'(1 + $urandom % 9);
            rd_pct = 30 + int'($urandom % 60);
            send_pkt(d, l, ($urandom % 5) == 0);
            if (($urandom % 4) == 0) repeat (int'($urandom % 3)) @(posedge clk);
        end
        rd_pct = 100;
        drain();

        // Maximum length packet (R1)
        send_pkt(0, 63, 1'b0);
        drain();

        finish_run();
    end

endmodule